// File: doc/BRIEF.md
# Two-Requester Grant Protocol Monitor

This block is a synthesizable run-time checker placed beside a two-port priority arbiter. Each clock it samples both request lines and both grant lines and tests them against three timing rules. First, a request on the high-priority port earns that port a grant in each of the next two cycles. Second, a cycle with no request at all earns the low-priority port a default grant in the following cycle. Third, the two grants are never high together.

The default-grant rule and the two-cycle hold can demand opposite things. Take a high request followed by an idle cycle: in the cycle after the idle one, the second held grant is still owed, and the default grant would be owed too. The monitor settles this by dropping the default-grant duty in any cycle where a high-port grant is still owed from an earlier request. A request on the low port alone creates no grant duty for the next cycle; only exclusivity is checked then.

Each rule has its own sticky flag, and a combined flag is their OR. A saturating cycle counter starts at reset. Its value is captured once, at the first breach of any rule. Checks are held off for the first two cycles after reset, while the history is still filling.

Top module: `grant_rule_monitor`

## Requirements
- R1: If req_hi is high in cycle t and gnt_hi is low in cycle t+1 or in cycle t+2, err_hold is high from the cycle after that low grant onward.
- R2: If req_hi and req_lo are both low in cycle t, req_hi was low in cycle t-1, and gnt_lo is low in cycle t+1, then err_idle is high from cycle t+2 onward.
- R3: The default-grant duty is waived in any cycle where a gnt_hi is still owed. After req_hi high, then an idle cycle, then gnt_hi=1 and gnt_lo=0, no flag is raised. Dropping gnt_hi in that cycle raises err_hold only, never err_idle.
- R4: A cycle in which only req_lo is high places no grant duty on the next cycle. Both grants low in that next cycle raises no flag.
- R5: gnt_hi and gnt_lo high in the same checked cycle sets err_excl from the next cycle onward.
- R6: err_hold, err_idle and err_excl stay high until reset once set. err_any is their OR.
- R7: No violation in the first two cycles after reset is released (cycle indices 0 and 1) sets any flag.
- R8: The cycle counter reads 0 in the first cycle after reset is released. first_err_cycle takes the index of the cycle holding the first violation, one cycle later. Later violations leave it unchanged.
- R9: While rst is high, all flags and first_err_cycle are 0 on the next clock edge, whatever was recorded before.
- R10: The cycle counter stops at 65535 (all ones for CNT_W=16). A first violation at or after that index records 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_hi | input | 1 | High-priority request seen on the bus |
| req_lo | input | 1 | Low-priority request seen on the bus |
| gnt_hi | input | 1 | Grant to the high-priority port |
| gnt_lo | input | 1 | Grant to the low-priority port (also the default grant) |
| err_hold | output | 1 | Sticky: two-cycle hold rule broken |
| err_idle | output | 1 | Sticky: default-grant rule broken |
| err_excl | output | 1 | Sticky: both grants high together |
| err_any | output | 1 | OR of the three sticky flags |
| first_err_cycle | output | CNT_W | Cycle index of the first violation |

## Verification
The default-grant duty and the second cycle of the two-cycle hold fall in the same cycle. This happens whenever a high request is followed by a fully idle cycle. The bench provokes it with exactly that pair of cycles, then drives the third cycle two ways. With the held grant present and no default grant, it expects silence. With both grants dropped, it expects only the hold flag and a first-violation index naming that third cycle. A scoreboard model derived from the rules predicts every registered flag.

// File: rtl/grm_pkg.sv
`timescale 1ns/1ps
package grm_pkg;

    // one bit per monitored rule, produced in the cycle the breach occurs
    typedef struct packed {
        logic hold;   // owed high-port grant missing
        logic idle;   // owed default grant missing
        logic excl;   // both grants asserted together
    } viol_t;

endpackage

// File: rtl/grm_history.sv
`timescale 1ns/1ps
// Request history: which high-port grants are owed and whether the
// previous cycle carried no request at all.
module grm_history #(
    parameter int HOLD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_hi,
    input  logic            req_lo,
    output logic [HOLD-1:0] hi_hist,
    output logic            idle_prev
);
    typedef struct packed {
        logic [HOLD-1:0] hi;    // bit k: req_hi seen k+1 cycles ago
        logic            idle;  // no request last cycle
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.hi[0] = req_hi;
        for (int i = 1; i < HOLD; i++) begin
            st_d.hi[i] = st_q.hi[i-1];
        end
        st_d.idle  = !req_hi && !req_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_hist   = st_q.hi;
    assign idle_prev = st_q.idle;

    // R2: an idle cycle always leaves no high-port duty from that cycle
    a_r2_idle_clears_hi: assert property (@(posedge clk) disable iff (rst)
        idle_prev |-> !hi_hist[0]);

endmodule

// File: rtl/grm_rules.sv
`timescale 1ns/1ps
// Rule evaluation for the current cycle.
module grm_rules
    import grm_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic [HOLD-1:0] hi_hist,
    input  logic            idle_prev,
    input  logic            gnt_hi,
    input  logic            gnt_lo,
    input  logic            chk_en,
    output viol_t           viol
);
    logic owe_hi;
    logic owe_lo;

    // a high-port grant is owed while any recent req_hi is in the window
    assign owe_hi = |hi_hist;
    // default grant owed only when no high-port grant is pending (R3 waiver)
    assign owe_lo = idle_prev && !owe_hi;

    always_comb begin
        viol      = '0;
        viol.hold = chk_en && owe_hi && !gnt_hi;
        viol.idle = chk_en && owe_lo && !gnt_lo;
        viol.excl = chk_en && gnt_hi && gnt_lo;
    end

endmodule

// File: rtl/grm_cycle.sv
`timescale 1ns/1ps
// Saturating cycle counter and check-enable after warm-up.
module grm_cycle #(
    parameter int CNT_W  = 16,
    parameter int WARMUP = 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cyc,
    output logic             chk_en
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] WARM    = CNT_W'(WARMUP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cyc_t;

    cyc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc    = st_q.cnt;
    assign chk_en = (st_q.cnt >= WARM);

    // R10: once at the top the count holds there
    a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
        (cyc == CNT_MAX) |=> (cyc == CNT_MAX));

endmodule

// File: rtl/grm_record.sv
`timescale 1ns/1ps
// Sticky per-rule flags and first-violation cycle capture.
module grm_record
    import grm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  viol_t            viol,
    input  logic [CNT_W-1:0] cyc,
    output logic             err_hold,
    output logic             err_idle,
    output logic             err_excl,
    output logic [CNT_W-1:0] first_err_cycle
);
    typedef struct packed {
        viol_t            flags;
        logic [CNT_W-1:0] first;
    } rec_t;

    rec_t st_d, st_q;
    logic any_now;
    logic any_seen;

    assign any_now  = viol.hold || viol.idle || viol.excl;
    assign any_seen = st_q.flags.hold || st_q.flags.idle || st_q.flags.excl;

    always_comb begin
        st_d            = st_q;
        st_d.flags.hold = st_q.flags.hold || viol.hold;
        st_d.flags.idle = st_q.flags.idle || viol.idle;
        st_d.flags.excl = st_q.flags.excl || viol.excl;
        if (any_now && !any_seen) begin
            st_d.first = cyc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_hold        = st_q.flags.hold;
    assign err_idle        = st_q.flags.idle;
    assign err_excl        = st_q.flags.excl;
    assign first_err_cycle = st_q.first;

    // R8: the recorded index is frozen once any flag is up
    a_r8_first_frozen: assert property (@(posedge clk) disable iff (rst)
        any_seen |=> $stable(first_err_cycle));
    // R6: each flag is sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        any_seen |=> (err_hold || err_idle || err_excl));

endmodule

// File: rtl/grant_rule_monitor.sv
`timescale 1ns/1ps
module grant_rule_monitor
    import grm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int HOLD  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_hi,
    input  logic             req_lo,
    input  logic             gnt_hi,
    input  logic             gnt_lo,
    output logic             err_hold,
    output logic             err_idle,
    output logic             err_excl,
    output logic             err_any,
    output logic [CNT_W-1:0] first_err_cycle
);
    // history needs HOLD cycles to fill before checks are trusted
    localparam int WARMUP = HOLD;

    logic [HOLD-1:0]  hi_hist;
    logic             idle_prev;
    logic [CNT_W-1:0] cyc;
    logic             chk_en;
    viol_t            viol;

    grm_history #(.HOLD(HOLD)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .req_hi    (req_hi),
        .req_lo    (req_lo),
        .hi_hist   (hi_hist),
        .idle_prev (idle_prev)
    );

    grm_cycle #(.CNT_W(CNT_W), .WARMUP(WARMUP)) u_cyc (
        .clk    (clk),
        .rst    (rst),
        .cyc    (cyc),
        .chk_en (chk_en)
    );

    grm_rules #(.HOLD(HOLD)) u_rules (
        .hi_hist   (hi_hist),
        .idle_prev (idle_prev),
        .gnt_hi    (gnt_hi),
        .gnt_lo    (gnt_lo),
        .chk_en    (chk_en),
        .viol      (viol)
    );

    grm_record #(.CNT_W(CNT_W)) u_rec (
        .clk             (clk),
        .rst             (rst),
        .viol            (viol),
        .cyc             (cyc),
        .err_hold        (err_hold),
        .err_idle        (err_idle),
        .err_excl        (err_excl),
        .first_err_cycle (first_err_cycle)
    );

    assign err_any = err_hold || err_idle || err_excl;

    // R1: a high request followed by a missing grant is flagged
    a_r1_hold_missed: assert property (@(posedge clk) disable iff (rst)
        (chk_en && $past(req_hi) && !gnt_hi) |=> err_hold);
    // R5: simultaneous grants are flagged
    a_r5_excl: assert property (@(posedge clk) disable iff (rst)
        (chk_en && gnt_hi && gnt_lo) |=> err_excl);
    // R7: nothing is recorded during warm-up
    a_r7_warmup_quiet: assert property (@(posedge clk) disable iff (rst)
        (!chk_en && !err_any) |=> !err_any);
    // R3: the waived default grant never raises the idle flag
    a_r3_waiver: assert property (@(posedge clk) disable iff (rst)
        (!err_idle && (|hi_hist)) |=> !err_idle);

endmodule

// File: tb/tb_grant_rule_monitor.sv
`timescale 1ns/1ps
module tb_grant_rule_monitor;
    localparam int CNT_W = 16;
    localparam int CMAX  = 65535;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_hi = 1'b0, req_lo = 1'b0, gnt_hi = 1'b0, gnt_lo = 1'b0;
    logic err_hold, err_idle, err_excl, err_any;
    logic [CNT_W-1:0] first_err_cycle;

    always #5 clk = ~clk;

    grant_rule_monitor #(.CNT_W(CNT_W), .HOLD(2)) dut (
        .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo),
        .gnt_hi(gnt_hi), .gnt_lo(gnt_lo), .err_hold(err_hold),
        .err_idle(err_idle), .err_excl(err_excl), .err_any(err_any),
        .first_err_cycle(first_err_cycle)
    );

    typedef struct {
        logic [2:0]       flags;   // {hold, idle, excl}
        logic             any;
        logic [CNT_W-1:0] first;
        string            tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state, built from the requirements
    int   m_cyc = 0;
    logic m_h1 = 0, m_h2 = 0, m_idle = 0;
    logic m_eh = 0, m_ei = 0, m_ex = 0;
    logic [CNT_W-1:0] m_first = '0;

    task automatic step(input logic r, input logic hi, input logic lo,
                        input logic ghi, input logic glo,
                        input string tag, input bit chk);
        exp_t e;
        logic owe, vh, vi, vx, en;
        @(negedge clk);
        rst = r; req_hi = hi; req_lo = lo; gnt_hi = ghi; gnt_lo = glo;
        if (r) begin
            // R9: everything returns to zero
            m_cyc = 0; m_h1 = 0; m_h2 = 0; m_idle = 0;
            m_eh = 0; m_ei = 0; m_ex = 0; m_first = '0;
        end else begin
            en  = (m_cyc >= 2);                 // R7 warm-up
            owe = m_h1 | m_h2;                  // R1 duty
            vh  = en & owe & !ghi;
            vi  = en & m_idle & !owe & !glo;    // R2 with R3 waiver
            vx  = en & ghi & glo;               // R5
            if ((vh | vi | vx) && !(m_eh | m_ei | m_ex))
                m_first = CNT_W'(m_cyc);        // R8
            m_eh |= vh; m_ei |= vi; m_ex |= vx; // R6
            m_h2 = m_h1; m_h1 = hi;
            m_idle = !hi && !lo;                // R4: req_lo alone is not idle
            if (m_cyc < CMAX) m_cyc++;          // R10
        end
        if (chk) begin
            e.flags = {m_eh, m_ei, m_ex};
            e.any   = m_eh | m_ei | m_ex;
            e.first = m_first;
            e.tag   = tag;
            q.push_back(e);
        end
    endtask

    // monitor: compares after each edge the result of that edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if ({err_hold, err_idle, err_excl} !== e.flags ||
                    err_any !== e.any || first_err_cycle !== e.first) begin
                    errors++;
                    $display("FAIL %s: flags=%b any=%b first=%0d expected flags=%b any=%b first=%0d",
                             e.tag, {err_hold, err_idle, err_excl}, err_any,
                             first_err_cycle, e.flags, e.any, e.first);
                end
            end
        end
    end

    task automatic do_reset();
        step(1, 0, 0, 0, 0, "R9", 1);
        step(1, 0, 0, 0, 0, "R9", 1);
    endtask

    initial begin
        // clean traffic with warm-up masking
        do_reset();
        step(0, 0, 1, 1, 1, "R7", 1);   // cycle 0: both grants, masked
        step(0, 0, 1, 1, 1, "R7", 1);   // cycle 1: masked
        step(0, 0, 1, 0, 0, "R4", 1);   // req_lo alone before: no duty
        step(0, 1, 1, 0, 0, "R4", 1);
        step(0, 0, 0, 1, 0, "R1", 1);   // first held grant
        step(0, 0, 1, 1, 0, "R3", 1);   // second held grant, default waived
        step(0, 0, 0, 0, 0, "R4", 1);
        step(0, 0, 0, 0, 1, "R2", 1);   // default grant after idle
        step(0, 0, 0, 0, 1, "R2", 1);

        // hold breach, then a later exclusivity breach
        do_reset();
        step(0, 0, 1, 0, 0, "R7", 1);
        step(0, 0, 1, 0, 0, "R7", 1);
        step(0, 1, 0, 0, 0, "R1", 1);   // cycle 2 request
        step(0, 0, 1, 1, 0, "R1", 1);
        step(0, 0, 1, 0, 0, "R1", 1);   // cycle 4 missing grant -> first=4
        step(0, 0, 1, 1, 1, "R5", 1);   // cycle 5 both grants
        step(0, 0, 1, 0, 0, "R8", 1);   // first stays 4
        step(0, 0, 1, 0, 0, "R6", 1);

        // reset clears recorded state, then an idle breach
        do_reset();
        step(0, 0, 1, 0, 0, "R7", 1);
        step(0, 0, 0, 0, 0, "R7", 1);   // cycle 1 idle
        step(0, 0, 0, 0, 0, "R2", 1);   // cycle 2 no default grant -> first=2
        step(0, 0, 1, 0, 1, "R6", 1);

        // default duty and second held grant in the same cycle
        do_reset();
        step(0, 0, 1, 0, 0, "R7", 1);
        step(0, 0, 1, 0, 0, "R7", 1);
        step(0, 1, 0, 0, 0, "R3", 1);
        step(0, 0, 0, 1, 0, "R3", 1);   // idle cycle while grant held
        step(0, 0, 1, 0, 0, "R3", 1);   // both dropped: hold only, first=4
        step(0, 0, 1, 0, 0, "R3", 1);

        // counter saturation
        do_reset();
        for (int i = 0; i < 70000; i++) step(0, 0, 1, 0, 0, "R10", 0);
        step(0, 0, 1, 1, 1, "R10", 1);  // first = 65535
        step(0, 0, 1, 0, 0, "R10", 1);

        @(posedge clk);
        #3;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule